// File: doc/BRIEF.md
# ISDN Link Activation Controller

This block is the control state machine that brings an S/T reference-point link up and takes it down again. One input chooses whether it acts as the network side (NT) or the terminal side (TE). It takes an activation-request bit and a deactivation-request bit from the control registers. From the line receiver it takes clean flags for bus activity, frame sync and the received A-bit. It also takes a 125 µs frame tick. From these it produces three things: the Info signal code the transmitter must send, the A-bit value for NT frames, and one status bit that carries either Sync or bus activity.

The NT side has a timed draining state. It stays there for a fixed number of frame ticks before it returns to idle. On the TE side, a small symbol generator drives the repeating Info1 wake-up pattern toward the line coder, stepped by a symbol tick. Signal detection and timing recovery on the line happen elsewhere.

Top module: `link_act_ctrl`

## Requirements
- R1: After reset the info code is 0, the A-bit output is 0, the line symbol is 0, and the status bit reports bus activity.
- R2: In NT mode, from idle, the block enters pending activation when bus activity is seen or when activation is requested, provided deactivation is not requested at the same time. Pending activation sends code 2 with A-bit 0. A held deactivation request keeps the NT idle (code 0).
- R3: In NT mode, frame sync during pending activation moves to activated: code 4 with A-bit 1. Loss of sync while activated returns to pending activation (code 2, A-bit 0).
- R4: In NT mode, a deactivation request from pending or activated enters draining, which sends code 0. Bus activity is ignored there until exactly TIMEOUT frame ticks (default 256) have been counted from entry. The block is then idle again.
- R5: In TE mode, an activation request from idle enters the calling state. That state sends code 1 while bus activity is absent and code 0 while it is present.
- R6: While code 1 is sent, line_sym steps through an 8-symbol cycle on each sym_tick: positive mark, negative mark, then six spaces, then it repeats. The encoding is space=0, positive=1, negative=2. line_sym is 0 whenever the code is not 1.
- R7: In TE mode, frame sync moves idle or calling to synchronized. Synchronized sends code 3 when sync is present and code 0 when it is absent. Sync together with A=1 enters activated (code 3). A=0 or loss of sync returns to synchronized.
- R8: A deactivation request forces code 0 from the second clock on. In TE mode the block returns to idle and stays there while the request is held.
- R9: The status bit reports frame_sync when act_req=1 and deact_req=0, and reports bus_act otherwise. A change in the selection takes effect only after the next frame tick.
- R10: info_code carries values 0..4 and is registered, so it changes one clock after the state change. tx_abit is 1 only together with code 4 in NT mode. The machine of the unselected mode is held idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| te_mode | input | 1 | 1 selects terminal side, 0 network side |
| frame_tick | input | 1 | One-clock pulse per 125 µs frame |
| sym_tick | input | 1 | One-clock pulse per line symbol |
| act_req | input | 1 | Activation request control bit |
| deact_req | input | 1 | Deactivation request control bit |
| bus_act | input | 1 | Receiver sees signal on the line |
| frame_sync | input | 1 | Receiver is frame-aligned |
| rx_abit | input | 1 | Received A-bit (TE mode) |
| info_code | output | 3 | Info code to transmit, 0..4 |
| tx_abit | output | 1 | A-bit for NT transmit frames |
| sync_ba | output | 1 | Sync or bus-activity status |
| line_sym | output | 2 | Info1 symbol: 0 space, 1 positive, 2 negative |

## Verification
Several relations are checked on every cycle. The info code stays within 0..4. The A-bit is only high together with code 4 in NT mode. A nonzero line symbol only appears while code 1 is sent. Code 0 follows a held deactivation request. Reset leaves the outputs idle.

The state sequences themselves need the bench scenarios to show them: the walk through each mode's Info sequence, the exact length of the draining timeout, the order of the Info1 symbols, and the frame-delayed switch of the status bit's meaning.

// File: rtl/lac_pkg.sv
// Shared types for the link activation controller.
// Assumes: info codes 0..4 fit in 3 bits; symbol encoding is fixed by R6.
package lac_pkg;
    typedef enum logic [2:0] {
        INFO0 = 3'd0,
        INFO1 = 3'd1,
        INFO2 = 3'd2,
        INFO3 = 3'd3,
        INFO4 = 3'd4
    } info_e;

    typedef enum logic [1:0] {
        NT_IDLE  = 2'd0,
        NT_ARM   = 2'd1,
        NT_LIVE  = 2'd2,
        NT_DRAIN = 2'd3
    } nt_state_e;

    typedef enum logic [1:0] {
        TE_IDLE = 2'd0,
        TE_CALL = 2'd1,
        TE_LOCK = 2'd2,
        TE_LIVE = 2'd3
    } te_state_e;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_POS   = 2'd1,
        SYM_NEG   = 2'd2
    } sym_e;
endpackage

// File: rtl/lac_drain_timer.sv
// Draining timer: counts frame ticks while run is high.
// It is cleared whenever run is low, so every entry starts from zero.
// done pulses on the tick that completes LIMIT ticks.
// Assumes: LIMIT >= 2.
module lac_drain_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Tick counter, cleared outside the draining state
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry on the last tick of the window
    always_comb begin
        done = run && tick && (cnt == LAST);
    end
endmodule

// File: rtl/lac_nt_fsm.sv
// Network-side activation machine: idle, pending activation, activated, draining.
// Produces the unregistered info code and A-bit for the current state.
// Assumes: input flags are synchronous; when enable is low the machine sits idle.
module lac_nt_fsm (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            act_req,
    input  logic            deact_req,
    input  logic            bus_act,
    input  logic            frame_sync,
    input  logic            timer_done,
    output logic            timer_run,
    output lac_pkg::info_e  info,
    output logic            abit
);
    import lac_pkg::*;

    nt_state_e state, state_nx;

    // State register; disabled mode forces idle
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= NT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state rules, deactivation request has priority
    always_comb begin
        state_nx = state;
        unique case (state)
            NT_IDLE: begin
                if (!deact_req && (act_req || bus_act)) state_nx = NT_ARM;
            end
            NT_ARM: begin
                if (deact_req)       state_nx = NT_DRAIN;
                else if (frame_sync) state_nx = NT_LIVE;
            end
            NT_LIVE: begin
                if (deact_req)        state_nx = NT_DRAIN;
                else if (!frame_sync) state_nx = NT_ARM;
            end
            NT_DRAIN: begin
                if (timer_done) state_nx = NT_IDLE;
            end
            default: state_nx = NT_IDLE;
        endcase
    end

    // Output decode per state
    always_comb begin
        timer_run = (state == NT_DRAIN);
        abit      = 1'b0;
        info      = INFO0;
        unique case (state)
            NT_ARM:  info = INFO2;
            NT_LIVE: begin
                info = INFO4;
                abit = 1'b1;
            end
            default: info = INFO0;
        endcase
    end
endmodule

// File: rtl/lac_te_fsm.sv
// Terminal-side activation machine: idle, calling, synchronized, activated.
// Produces the unregistered info code from state and line flags.
// Assumes: input flags are synchronous; when enable is low the machine sits idle.
module lac_te_fsm (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            act_req,
    input  logic            deact_req,
    input  logic            bus_act,
    input  logic            frame_sync,
    input  logic            rx_abit,
    output lac_pkg::info_e  info
);
    import lac_pkg::*;

    te_state_e state, state_nx;

    // State register; disabled mode forces idle
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= TE_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state rules; deactivation request wins from every state
    always_comb begin
        state_nx = state;
        if (deact_req) begin
            state_nx = TE_IDLE;
        end else begin
            unique case (state)
                TE_IDLE: begin
                    if (frame_sync)   state_nx = TE_LOCK;
                    else if (act_req) state_nx = TE_CALL;
                end
                TE_CALL: begin
                    if (frame_sync) state_nx = TE_LOCK;
                end
                TE_LOCK: begin
                    if (frame_sync && rx_abit) state_nx = TE_LIVE;
                end
                TE_LIVE: begin
                    if (!frame_sync || !rx_abit) state_nx = TE_LOCK;
                end
                default: state_nx = TE_IDLE;
            endcase
        end
    end

    // Info selection per state and line flags
    always_comb begin
        unique case (state)
            TE_CALL: info = bus_act ? INFO0 : INFO1;
            TE_LOCK: info = frame_sync ? INFO3 : INFO0;
            TE_LIVE: info = INFO3;
            default: info = INFO0;
        endcase
    end
endmodule

// File: rtl/lac_wake_gen.sv
// Wake-up pattern generator: while active, steps through PAT_LEN symbols on
// sym_tick. The first two are the positive and the negative mark, the rest
// are spaces. It restarts from symbol 0 whenever it goes inactive.
// Assumes: PAT_LEN >= 3.
module lac_wake_gen #(
    parameter int PAT_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          sym_tick,
    output lac_pkg::sym_e sym
);
    import lac_pkg::*;

    localparam int IW = $clog2(PAT_LEN);
    localparam logic [IW-1:0] LAST = IW'(PAT_LEN - 1);

    logic [IW-1:0] idx;

    // Pattern position, wraps at the pattern length
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            idx <= '0;
        end else if (sym_tick) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    // Symbol decode for the current position
    always_comb begin
        if (!active)                  sym = SYM_SPACE;
        else if (idx == '0)           sym = SYM_POS;
        else if (idx == IW'(1))       sym = SYM_NEG;
        else                          sym = SYM_SPACE;
    end
endmodule

// File: rtl/link_act_ctrl.sv
// Link activation controller top. It selects the NT or TE machine by te_mode,
// registers the info code and A-bit, drives the Info1 symbol generator and
// the frame-delayed Sync/BA status select.
// Assumes: all inputs are synchronous to clk; frame_tick and sym_tick are
// single-cycle pulses.
module link_act_ctrl #(
    parameter int TIMEOUT = 256,
    parameter int PAT_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       te_mode,
    input  logic       frame_tick,
    input  logic       sym_tick,
    input  logic       act_req,
    input  logic       deact_req,
    input  logic       bus_act,
    input  logic       frame_sync,
    input  logic       rx_abit,
    output logic [2:0] info_code,
    output logic       tx_abit,
    output logic       sync_ba,
    output logic [1:0] line_sym
);
    import lac_pkg::*;

    info_e nt_info, te_info, info_q;
    logic  nt_abit, abit_q;
    logic  tmr_run, tmr_done;
    logic  sel_sync;
    sym_e  sym;

    lac_drain_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (frame_tick),
        .done  (tmr_done)
    );

    lac_nt_fsm u_nt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (!te_mode),
        .act_req    (act_req),
        .deact_req  (deact_req),
        .bus_act    (bus_act),
        .frame_sync (frame_sync),
        .timer_done (tmr_done),
        .timer_run  (tmr_run),
        .info       (nt_info),
        .abit       (nt_abit)
    );

    lac_te_fsm u_te (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (te_mode),
        .act_req    (act_req),
        .deact_req  (deact_req),
        .bus_act    (bus_act),
        .frame_sync (frame_sync),
        .rx_abit    (rx_abit),
        .info       (te_info)
    );

    lac_wake_gen #(.PAT_LEN(PAT_LEN)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (info_q == INFO1),
        .sym_tick (sym_tick),
        .sym      (sym)
    );

    // Output registers for the transmit code and A-bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q <= INFO0;
            abit_q <= 1'b0;
        end else begin
            info_q <= te_mode ? te_info : nt_info;
            abit_q <= !te_mode && nt_abit;
        end
    end

    // Status meaning latched at each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_sync <= 1'b0;
        end else if (frame_tick) begin
            sel_sync <= act_req && !deact_req;
        end
    end

    // Port drive
    always_comb begin
        info_code = info_q;
        tx_abit   = abit_q;
        sync_ba   = sel_sync ? frame_sync : bus_act;
        line_sym  = sym;
    end
endmodule

// File: rtl/lac_checker.sv
// Property checker for link_act_ctrl, attached by bind.
// Assumes: synchronous active-low reset; a cycle counter gates $past use.
module lac_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       te_mode,
    input logic       deact_req,
    input logic [2:0] info_code,
    input logic       tx_abit,
    input logic [1:0] line_sym
);
    logic [1:0] since_rst;

    // Cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (info_code == 3'd0 && !tx_abit && line_sym == 2'd0));

    // R10
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_code <= 3'd4);

    // R3
    abit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abit |-> (info_code == 3'd4));

    // R10
    abit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abit && since_rst != 2'd0) |-> !$past(te_mode));

    // R6
    sym_only_info1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sym != 2'd0) |-> (info_code == 3'd1));

    // R8
    deact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(deact_req, 2)) |-> (info_code == 3'd0));
endmodule

bind link_act_ctrl lac_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .te_mode   (te_mode),
    .deact_req (deact_req),
    .info_code (info_code),
    .tx_abit   (tx_abit),
    .line_sym  (line_sym)
);

// File: tb/tb_link_act_ctrl.sv
// Testbench: vector table walk, then directed reset and corner-case tests.
module tb_link_act_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       te_mode, frame_tick, sym_tick;
    logic       act_req, deact_req, bus_act, frame_sync, rx_abit;
    logic [2:0] info_code;
    logic       tx_abit, sync_ba;
    logic [1:0] line_sym;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    link_act_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .te_mode    (te_mode),
        .frame_tick (frame_tick),
        .sym_tick   (sym_tick),
        .act_req    (act_req),
        .deact_req  (deact_req),
        .bus_act    (bus_act),
        .frame_sync (frame_sync),
        .rx_abit    (rx_abit),
        .info_code  (info_code),
        .tx_abit    (tx_abit),
        .sync_ba    (sync_ba),
        .line_sym   (line_sym)
    );

    // {te_mode, ar, dr, ba, fs, ra, info[2:0], abit}
    localparam int NV = 15;
    localparam logic [9:0] VEC [NV] = '{
        10'b000000_000_0, // R1 NT idle
        10'b000100_010_0, // R2 bus activity -> pending, Info2
        10'b000010_100_1, // R3 sync -> activated, Info4, A=1
        10'b000000_010_0, // R3 sync lost -> pending
        10'b000010_100_1, // R3 back to activated
        10'b100000_000_0, // R10 switch to TE, idle
        10'b110000_001_0, // R5 calling, no activity -> Info1
        10'b110100_000_0, // R5 calling, activity -> Info0
        10'b110110_011_0, // R7 sync -> synchronized, Info3
        10'b110111_011_0, // R7 A=1 -> activated, Info3
        10'b110110_011_0, // R7 A=0 -> synchronized
        10'b110100_000_0, // R7 sync lost -> Info0
        10'b110111_011_0, // R7 activated again
        10'b101111_000_0, // R8 deactivation -> idle
        10'b100111_011_0  // R7 sync from idle
    };
    localparam int VREQ [NV] = '{1, 2, 3, 3, 3, 10, 5, 5, 7, 7, 7, 7, 7, 8, 7};

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        te_mode = 0; frame_tick = 0; sym_tick = 0;
        act_req = 0; deact_req = 0; bus_act = 0; frame_sync = 0; rx_abit = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pulse_frame(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); frame_tick = 1;
            @(negedge clk); frame_tick = 0;
        end
    endtask

    task automatic pulse_sym();
        @(negedge clk); sym_tick = 1;
        @(negedge clk); sym_tick = 0;
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 info", {1'b0, info_code}, 4'd0);
        check("R1 abit", {3'b0, tx_abit}, 4'd0);
        check("R1 sym", {2'b0, line_sym}, 4'd0);
        bus_act = 1;
        #1;
        check("R1 status=BA", {3'b0, sync_ba}, 4'd1);
        bus_act = 0;

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {te_mode, act_req, deact_req, bus_act, frame_sync, rx_abit} = VEC[v][9:4];
            settle();
            check($sformatf("R%0d vec%0d info", VREQ[v], v), {1'b0, info_code}, {1'b0, VEC[v][3:1]});
            check($sformatf("R%0d vec%0d abit", VREQ[v], v), {3'b0, tx_abit}, {3'b0, VEC[v][0]});
        end

        // R2 deactivation request blocks activation from NT idle
        do_reset();
        act_req = 1; deact_req = 1;
        settle();
        check("R2 DR wins", {1'b0, info_code}, 4'd0);

        // R6 Info1 symbol sequence
        do_reset();
        te_mode = 1; act_req = 1;
        settle();
        check("R6 code1", {1'b0, info_code}, 4'd1);
        check("R6 sym0 pos", {2'b0, line_sym}, 4'd1);
        for (int s = 1; s <= 8; s++) begin
            pulse_sym();
            check($sformatf("R6 sym%0d", s), {2'b0, line_sym},
                  (s == 1) ? 4'd2 : (s == 8) ? 4'd1 : 4'd0);
        end
        bus_act = 1;
        settle();
        check("R6 sym off", {2'b0, line_sym}, 4'd0);

        // R9 status select switches only at frame tick
        do_reset();
        act_req = 1; bus_act = 1; frame_sync = 0;
        settle();
        check("R9 before tick BA", {3'b0, sync_ba}, 4'd1);
        pulse_frame(1);
        check("R9 after tick Sync", {3'b0, sync_ba}, 4'd0);
        deact_req = 1;
        settle();
        check("R9 DR held until tick", {3'b0, sync_ba}, 4'd0);
        pulse_frame(1);
        check("R9 DR after tick BA", {3'b0, sync_ba}, 4'd1);

        // R4 draining lasts exactly TIMEOUT ticks
        do_reset();
        act_req = 1; frame_sync = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 activated first", {1'b0, info_code}, 4'd4);
        act_req = 0; deact_req = 1;
        @(negedge clk);
        deact_req = 0; frame_sync = 0;
        pulse_frame(255);
        bus_act = 1;
        settle();
        @(negedge clk);
        check("R4 still draining at 255", {1'b0, info_code}, 4'd0);
        pulse_frame(1);
        settle();
        check("R4 idle after 256 then pending", {1'b0, info_code}, 4'd2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule